// File: doc/BRIEF.md
# Control Endpoint Transfer Size Tracker

This block keeps the receive-side transfer bookkeeping for a USB control endpoint. It holds three counters: a SETUP packet allowance, a one-bit packet count and a byte transfer size. Software programs all three through a 32-bit register port while the endpoint is idle. Software then arms the endpoint, and from that point the hardware owns the counters. Each packet committed to the receive FIFO updates them.

When the counters run out, the block disarms the endpoint by itself. If the byte budget was fully consumed, it also reports completion: a one-cycle pulse on one output and a sticky flag on another. Software clears the sticky flag by writing one to bit 31. A SETUP packet that arrives after the allowance is used up is reported on an overflow pulse. When the scatter/gather input is high, the register port is closed: reads return zero and writes do nothing.

Top module: `ep0_xfer_tracker`

## Requirements
- R1: A register read returns the SETUP allowance in bits 30:29, the packet count in bit 19 and the byte size in bits 6:0. Every other bit reads as zero.
- R2: After reset, all three counters, the armed state, the sticky flag and both pulse outputs are zero.
- R3: A register write loads the three fields on the next clock edge only while the endpoint is not armed. A write made while the endpoint is armed leaves the fields unchanged.
- R4: While `sg_mode` is 1, `reg_rdata` is zero, and a write changes neither the fields nor the sticky flag.
- R5: Each packet commit accepted while the endpoint is armed lowers the byte size by `pkt_len`. The result stops at zero.
- R6: Each accepted commit clears the packet count to zero.
- R7: An accepted commit with `pkt_setup` high lowers a nonzero SETUP allowance by one. Allowance values 1, 2 and 3 permit that many SETUP packets.
- R8: An accepted SETUP commit while the allowance is zero produces a one-cycle `setup_ovf` pulse on the next cycle and leaves the allowance at zero.
- R9: A pulse on `ep_en_set` arms the endpoint on the next edge. While the endpoint is armed and either the byte size or the packet count is zero, it disarms on the next edge.
- R10: `xfer_done` pulses for exactly one cycle, in the same cycle the endpoint disarms, and only if the byte size was zero when the endpoint disarmed.
- R11: `done_flag` becomes 1 together with `xfer_done` and holds until a register write with bit 31 set, made outside scatter/gather mode, clears it. When a set and a clear fall in the same cycle, the set wins.
- R12: Packet commits made while the endpoint is not armed change no counter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |
| ep_en_set | input | 1 | Request to arm the endpoint |
| ep_en | output | 1 | Endpoint armed |
| sg_mode | input | 1 | Scatter/gather mode; closes the register port |
| pkt_commit | input | 1 | A received packet was committed to the FIFO |
| pkt_len | input | 7 | Byte length of the committed packet |
| pkt_setup | input | 1 | The committed packet is a SETUP packet |
| xfer_done | output | 1 | One-cycle transfer-complete pulse |
| done_flag | output | 1 | Sticky transfer-complete status |
| setup_ovf | output | 1 | One-cycle excess-SETUP pulse |

## Verification
The assertions assume that `pkt_commit` is a single-cycle event with `pkt_len` and `pkt_setup` valid in that same cycle. They also assume that `sg_mode` and `reg_wr` are synchronous levels. Nothing is assumed about the order in which writes, arm requests and commits arrive. The random stimulus therefore freely overlaps writes with commits and arm requests, includes commits while the endpoint is idle, and toggles `sg_mode` only occasionally so that both port states stay long enough to be exercised. Packet lengths span the full 7-bit range, so saturation is reached often.

// File: rtl/ep0_xfer_tracker.sv
module ep0_xfer_tracker (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        ep_en_set,
  output logic        ep_en,
  input  logic        sg_mode,
  input  logic        pkt_commit,
  input  logic [6:0]  pkt_len,
  input  logic        pkt_setup,
  output logic        xfer_done,
  output logic        done_flag,
  output logic        setup_ovf
);
  localparam int SZ_W = 7;

  logic [1:0]      sup_q;
  logic            pkt_q;
  logic [SZ_W-1:0] size_q;

  wire sw_ok   = reg_wr && !sg_mode;
  wire load    = sw_ok && !ep_en;
  wire take    = pkt_commit && ep_en;
  wire finish  = ep_en && (size_q == '0 || !pkt_q);
  wire [SZ_W:0] diff = {1'b0, size_q} - {1'b0, pkt_len};
  wire [SZ_W-1:0] size_nx = diff[SZ_W] ? '0 : diff[SZ_W-1:0];

  assign reg_rdata = sg_mode ? 32'd0 : {1'b0, sup_q, 9'd0, pkt_q, 12'd0, size_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sup_q <= '0; pkt_q <= 1'b0; size_q <= '0;
      ep_en <= 1'b0; xfer_done <= 1'b0; done_flag <= 1'b0; setup_ovf <= 1'b0;
    end else begin
      setup_ovf <= take && pkt_setup && sup_q == '0;
      xfer_done <= finish && size_q == '0;
      if (finish && size_q == '0) done_flag <= 1'b1;
      else if (sw_ok && reg_wdata[31]) done_flag <= 1'b0;
      if (finish) ep_en <= 1'b0;
      else if (ep_en_set) ep_en <= 1'b1;
      if (load) begin
        sup_q  <= reg_wdata[30:29];
        pkt_q  <= reg_wdata[19];
        size_q <= reg_wdata[SZ_W-1:0];
      end else if (take) begin
        size_q <= size_nx;
        pkt_q  <= 1'b0;
        if (pkt_setup && sup_q != '0) sup_q <= sup_q - 2'd1;
      end
    end
  end

  assert_hold_armed_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ep_en && !pkt_commit) |=> ($stable(size_q) && $stable(sup_q) && $stable(pkt_q)));

  assert_sg_locked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sg_mode && !ep_en) |=> ($stable(size_q) && $stable(sup_q) && $stable(pkt_q)));

  assert_size_down_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_commit && ep_en) |=> (size_q <= $past(size_q)));

  assert_pkt_cleared_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_commit && ep_en) |=> !pkt_q);

  assert_ovf_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    setup_ovf |-> ($past(sup_q) == 2'd0 && sup_q == 2'd0));

  assert_done_disarms_R9: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |-> !ep_en);

  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> !xfer_done);

  assert_flag_follows_R11: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |-> done_flag);

  assert_idle_commit_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!ep_en && !reg_wr) |=> ($stable(size_q) && $stable(sup_q) && $stable(pkt_q)));
endmodule

// File: tb/tb_ep0_xfer_tracker.sv
module tb_ep0_xfer_tracker;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic ep_en_set = 1'b0;
  logic ep_en;
  logic sg_mode = 1'b0;
  logic pkt_commit = 1'b0;
  logic [6:0] pkt_len = '0;
  logic pkt_setup = 1'b0;
  logic xfer_done, done_flag, setup_ovf;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [1:0] m_sup;
  logic       m_pkt;
  logic [6:0] m_size;
  logic       m_en, m_done, m_flag, m_ovf;

  always #2.5ns clk = ~clk;

  ep0_xfer_tracker dut (.*);

  function automatic logic [31:0] pack(input logic [1:0] s, input logic p, input logic [6:0] z);
    logic [31:0] r = '0;
    r[30:29] = s; r[19] = p; r[6:0] = z;
    return r;
  endfunction

  function automatic logic [6:0] sat_sub(input logic [6:0] a, input logic [6:0] b);
    return (b > a) ? 7'd0 : a - b;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    check("R1/R4 reg_rdata", reg_rdata, sg_mode ? 32'd0 : pack(m_sup, m_pkt, m_size));
    check("R9 ep_en", {31'd0, ep_en}, {31'd0, m_en});
    check("R10 xfer_done", {31'd0, xfer_done}, {31'd0, m_done});
    check("R11 done_flag", {31'd0, done_flag}, {31'd0, m_flag});
    check("R8 setup_ovf", {31'd0, setup_ovf}, {31'd0, m_ovf});
  endtask

  task automatic tick(input logic wr, input logic [31:0] wd, input logic ens,
                      input logic cm, input logic [6:0] len, input logic st);
    logic fin, sw, take;
    reg_wr = wr; reg_wdata = wd; ep_en_set = ens;
    pkt_commit = cm; pkt_len = len; pkt_setup = st;
    @(posedge clk);
    sw   = wr && !sg_mode;
    take = cm && m_en;
    fin  = m_en && (m_size == 0 || !m_pkt);
    m_ovf  = take && st && m_sup == 0;
    m_done = fin && m_size == 0;
    if (m_done) m_flag = 1'b1;
    else if (sw && wd[31]) m_flag = 1'b0;
    if (sw && !m_en) begin
      m_sup = wd[30:29]; m_pkt = wd[19]; m_size = wd[6:0];
    end else if (take) begin
      m_size = sat_sub(m_size, len);
      m_pkt = 1'b0;
      if (st && m_sup != 0) m_sup = m_sup - 2'd1;
    end
    if (fin) m_en = 1'b0;
    else if (ens) m_en = 1'b1;
    @(negedge clk);
    compare();
  endtask

  task automatic idle(); tick(1'b0, '0, 1'b0, 1'b0, '0, 1'b0); endtask
  task automatic wr(input logic [31:0] d); tick(1'b1, d, 1'b0, 1'b0, '0, 1'b0); endtask
  task automatic arm(); tick(1'b0, '0, 1'b1, 1'b0, '0, 1'b0); endtask
  task automatic pkt(input logic [6:0] l, input logic s); tick(1'b0, '0, 1'b0, 1'b1, l, s); endtask

  initial begin
    #(200000 * 5ns);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240607));
    m_sup = 0; m_pkt = 0; m_size = 0; m_en = 0; m_done = 0; m_flag = 0; m_ovf = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    compare();                                   // R2 reset state
    check("R2 rdata zero", reg_rdata, 32'd0);

    wr(pack(2'd3, 1'b1, 7'd64) | 32'h1F00_7F80); // R1 reserved bits read zero
    check("R1 layout", reg_rdata, 32'h6008_0040);
    arm();
    wr(pack(2'd1, 1'b1, 7'd5));                  // R3 dropped while armed
    check("R3 armed write dropped", reg_rdata, 32'h6008_0040);
    pkt(7'd8, 1'b1);                             // R5 R6 R7
    check("R5 size 56 after 8-byte SETUP", {25'd0, reg_rdata[6:0]}, 32'd56);
    check("R7 allowance 3->2", {30'd0, reg_rdata[30:29]}, 32'd2);
    idle();                                      // R9 disarm, R10 no pulse
    check("R10 no done with bytes left", {31'd0, xfer_done}, 32'd0);

    wr(pack(2'd0, 1'b1, 7'd8)); arm();
    pkt(7'd8, 1'b1);                             // R8 overflow
    check("R8 ovf pulse", {31'd0, setup_ovf}, 32'd1);
    idle();
    check("R10 done pulse", {31'd0, xfer_done}, 32'd1);
    idle();
    check("R10 single cycle", {31'd0, xfer_done}, 32'd0);
    check("R11 sticky", {31'd0, done_flag}, 32'd1);
    wr(32'h8000_0000);
    check("R11 w1c", {31'd0, done_flag}, 32'd0);

    wr(pack(2'd2, 1'b1, 7'd5)); arm();
    pkt(7'd100, 1'b0);                           // R5 saturation
    check("R5 saturate", {25'd0, reg_rdata[6:0]}, 32'd0);
    idle(); idle();

    wr(pack(2'd1, 1'b1, 7'd20));
    pkt(7'd3, 1'b0);                             // R12 idle commit ignored
    check("R12 idle commit", reg_rdata, pack(2'd1, 1'b1, 7'd20));

    sg_mode = 1'b1;
    wr(pack(2'd3, 1'b0, 7'd9) | 32'h8000_0000);  // R4
    check("R4 read zero", reg_rdata, 32'd0);
    sg_mode = 1'b0;
    idle();
    check("R4 write ignored", reg_rdata, pack(2'd1, 1'b1, 7'd20));

    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 39) == 0) sg_mode = ~sg_mode;
      tick($urandom_range(0, 9) == 0,
           $urandom() | ($urandom_range(0, 3) != 0 ? 32'h0008_0000 : 32'h0),
           $urandom_range(0, 7) == 0,
           $urandom_range(0, 2) == 0,
           7'($urandom_range(0, 127)),
           $urandom_range(0, 2) == 0);
    end

    finished = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule